// File: doc/BRIEF.md
# Prescaled Event Spy Tap

The tap sits inline on an event stream. Data words pass through on a valid/ready channel, and the last word of each event is flagged. The tap can copy whole events into a pair of side buffers that a monitoring processor reads later. Each copied event puts its words into a spy data FIFO. After its final word it puts one length entry into a spy length FIFO. A small register port picks the selection mode (never, every event, or one event in every n), the ratio n (1 to 65536), and a debug flag.

The pass-through is combinational. `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and data and last are wired straight through. Downstream back-pressure therefore reaches the source in the same cycle. A word moves when `in_valid && in_ready`.

The decision to copy is taken once per event, on the handshake of its first word. In normal operation the tap never holds the stream. If a selected event begins while either spy FIFO reports almost-full, the tap skips that copy and increments a saturating drop counter. With the debug flag set, the tap instead holds the stream until there is room, so no selected event is lost.

Top module: `spy_tap`

## Requirements
- R1: After reset the mode is "never" (code 0), the debug flag is clear, `drop_count` is 0, and no spy write occurs until the register port is written.
- R2: With mode code 0 or code 3, no event is copied.
- R3: With mode code 1, every event is copied word for word into the spy data FIFO, in order.
- R4: With mode code 2, `cfg_ratio_m1` holds n−1. The first event after a register write is copied, then every n-th event after it.
- R5: A ratio field of 0xFFFF gives n = 65536, so only the first of a short run of events is copied.
- R6: For each copied event the length port is written once, one cycle after the event's last data word is written. The value is the event's word count.
- R7: In normal mode the tap never holds the stream (`in_ready == out_ready`). A selected event whose first word arrives while either almost-full flag is high is not copied, and `drop_count` increments by 1.
- R8: An event that has started copying is copied in full, even if the almost-full flags rise part-way through it.
- R9: In debug mode the first word of a selected event is held (`in_ready` and `out_valid` low) while either almost-full flag is high. During a copied event, words are held while the data almost-full flag is high. No such event is dropped.
- R10: A write on the register port restarts the one-in-n counter.
- R11: `drop_count` saturates at its maximum value.
- R12: With `out_ready` low, the input sees `in_ready` low and no spy write happens. Output data and last always equal input data and last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Last word of event |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Last word of event |
| spy_dat_we | output | 1 | Spy data FIFO write strobe |
| spy_dat_wd | output | DATA_W | Spy data FIFO write word |
| spy_dat_afull | input | 1 | Spy data FIFO almost full |
| spy_len_we | output | 1 | Spy length FIFO write strobe |
| spy_len_wd | output | LEN_W | Event word count |
| spy_len_afull | input | 1 | Spy length FIFO almost full |
| cfg_we | input | 1 | Register write strobe |
| cfg_mode | input | 2 | 0 never, 1 all, 2 one-in-n, 3 never |
| cfg_ratio_m1 | input | RATIO_W | n−1 for one-in-n |
| cfg_debug | input | 1 | Hold stream instead of dropping |
| drop_count | output | DROP_W | Saturating count of skipped copies |

## Verification
The bench sweeps the one-in-n ratio over several small values and the largest one. Against a counter computed in the bench, it checks which events appear in the spy FIFOs. A tap that failed to restart its counter on a register write, or that advanced it on the wrong event, copies the wrong events. The bench raises almost-full at event start and again mid-event. A tap that truncated a copy or stalled in normal mode would show short copies or held input. The bench also checks for a missing stall or a lost event in debug mode, for a length written early or miscounted, and for a drop counter that wraps instead of holding at its maximum.

// File: rtl/spy_tap_pkg.sv
package spy_tap_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_EVERY = 2'd1,
    PS_RATIO = 2'd2,
    PS_RSVD  = 2'd3
  } ps_mode_e;
endpackage

// File: rtl/spy_prescale.sv
module spy_prescale
  import spy_tap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  ps_mode_e      mode,
  input  logic [CW-1:0] ratio_m1,
  input  logic          ev_start,
  output logic          pick
);
  logic [CW-1:0] cnt;

  always_comb begin
    unique case (mode)
      PS_EVERY: pick = 1'b1;
      PS_RATIO: pick = (cnt == '0);
      default:  pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (ev_start && mode == PS_RATIO) begin
      cnt <= (cnt == ratio_m1) ? '0 : cnt + 1'b1;
    end
  end

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R4
  ratio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && ev_start && mode == PS_RATIO && cnt != ratio_m1) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/spy_capture.sv
module spy_capture #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          pick,
  input  logic          debug,
  input  logic          dat_af,
  input  logic          len_af,
  output logic          ev_start,
  output logic          drop,
  output logic          dat_we,
  output logic [DW-1:0] dat_wd,
  output logic          len_we,
  output logic [LW-1:0] len_wd
);
  logic          in_event;
  logic          spying;
  logic [LW-1:0] wcnt;
  logic          first, full_any, hold, xfer, take_now;

  assign first    = ~in_event;
  assign full_any = dat_af | len_af;
  assign hold     = debug & ((first & pick & full_any) | (in_event & spying & dat_af));

  assign out_valid = in_valid & ~hold;
  assign in_ready  = out_ready & ~hold;
  assign out_data  = in_data;
  assign out_last  = in_last;

  assign xfer     = in_valid & in_ready;
  assign take_now = first ? (pick & ~full_any) : spying;
  assign ev_start = xfer & first;
  assign drop     = ev_start & pick & full_any;
  assign dat_we   = xfer & take_now;
  assign dat_wd   = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_event <= 1'b0;
      spying   <= 1'b0;
      wcnt     <= '0;
      len_we   <= 1'b0;
      len_wd   <= '0;
    end else begin
      len_we <= dat_we & in_last;
      if (dat_we && in_last) len_wd <= wcnt + 1'b1;
      if (xfer) begin
        in_event <= ~in_last;
        spying   <= take_now & ~in_last;
      end
      if (dat_we) wcnt <= in_last ? '0 : wcnt + 1'b1;
    end
  end

  // R6
  len_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |-> $past(dat_we && in_last));

  // R7
  no_hold_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !debug |-> (in_ready == out_ready));

  // R8
  whole_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dat_we && !in_last) && in_valid && in_ready) |-> dat_we);

  // R9
  debug_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debug && first && pick && full_any) |-> (!out_valid && !dat_we));

  // R12
  write_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |-> (out_valid && out_ready));
endmodule

// File: rtl/spy_sat_counter.sv
module spy_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spy_tap.sv
module spy_tap
  import spy_tap_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int RATIO_W = 16,
  parameter int DROP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last,
  output logic               spy_dat_we,
  output logic [DATA_W-1:0]  spy_dat_wd,
  input  logic               spy_dat_afull,
  output logic               spy_len_we,
  output logic [LEN_W-1:0]   spy_len_wd,
  input  logic               spy_len_afull,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_mode,
  input  logic [RATIO_W-1:0] cfg_ratio_m1,
  input  logic               cfg_debug,
  output logic [DROP_W-1:0]  drop_count
);
  ps_mode_e           mode_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               debug_q;
  logic               pick, ev_start, drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= PS_OFF;
      ratio_q <= '0;
      debug_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= ps_mode_e'(cfg_mode);
      ratio_q <= cfg_ratio_m1;
      debug_q <= cfg_debug;
    end
  end

  spy_prescale #(.CW(RATIO_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .mode(mode_q),
    .ratio_m1(ratio_q), .ev_start(ev_start), .pick(pick)
  );

  spy_capture #(.DW(DATA_W), .LW(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .pick(pick), .debug(debug_q), .dat_af(spy_dat_afull), .len_af(spy_len_afull),
    .ev_start(ev_start), .drop(drop),
    .dat_we(spy_dat_we), .dat_wd(spy_dat_wd), .len_we(spy_len_we), .len_wd(spy_len_wd)
  );

  spy_sat_counter #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop), .count(drop_count)
  );

  // R2
  off_no_spy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && (mode_q == PS_OFF || mode_q == PS_RSVD)) |-> !spy_dat_we);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!spy_len_we && drop_count == '0));
endmodule

// File: tb/sim_spy_tap.sv
module sim_spy_tap;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int DROP_MAX = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic       spy_dat_we, spy_len_we;
  logic [7:0] spy_dat_wd, spy_len_wd;
  logic       spy_dat_afull = 1'b0, spy_len_afull = 1'b0;
  logic       cfg_we = 1'b0, cfg_debug = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [15:0] cfg_ratio_m1 = '0;
  logic [2:0] drop_count;

  spy_tap #(.DATA_W(8), .LEN_W(8), .RATIO_W(16), .DROP_W(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .spy_dat_we(spy_dat_we), .spy_dat_wd(spy_dat_wd), .spy_dat_afull(spy_dat_afull),
    .spy_len_we(spy_len_we), .spy_len_wd(spy_len_wd), .spy_len_afull(spy_len_afull),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_ratio_m1(cfg_ratio_m1),
    .cfg_debug(cfg_debug), .drop_count(drop_count)
  );

  always #(HALF) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_d[$], got_d[$];
  int exp_l[$], got_l[$];
  int m_mode = 0, m_nm1 = 0, m_pc = 0, m_dbg = 0, m_drop = 0;
  logic [7:0] wseq = 8'd1;
  int waits_normal = 0, stall_seen = 0, spy_noxfer = 0, pass_bad = 0, len_late = 0;
  int sidx = 0, last_dw_idx = -10;
  bit done_flag = 0;

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial forever begin
    @(negedge clk);
    #(HALF - 1);
    sidx++;
    if (spy_dat_we) begin
      got_d.push_back(spy_dat_wd);
      if (!(in_valid && in_ready)) spy_noxfer++;
      if (in_last) last_dw_idx = sidx;
    end
    if (spy_len_we) begin
      got_l.push_back(int'(spy_len_wd));
      if (last_dw_idx != sidx - 1) len_late++;
    end
    if (in_valid && (out_data != in_data || out_last != in_last)) pass_bad++;
    if (rst_n && m_dbg == 0 && (in_ready != out_ready || out_valid != in_valid)) pass_bad++;
  end

  task automatic cfg(input int mode, input int nm1, input int dbg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = mode[1:0]; cfg_ratio_m1 = nm1[15:0]; cfg_debug = dbg[0];
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = mode; m_nm1 = nm1; m_dbg = dbg; m_pc = 0;
  endtask

  task automatic send_event(input int len, input bit af0, input bit afm);
    bit sel, keep;
    sel = (m_mode == 1) || (m_mode == 2 && m_pc == 0);
    if (m_mode == 2) m_pc = (m_pc == m_nm1) ? 0 : m_pc + 1;
    keep = sel && (!af0 || m_dbg != 0);
    if (sel && af0 && m_dbg == 0 && m_drop < DROP_MAX) m_drop++;
    for (int i = 0; i < len; i++) begin
      bit done = 0;
      int waits = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = wseq; in_last = (i == len - 1);
      spy_dat_afull = (i == 0) ? af0 : afm;
      spy_len_afull = spy_dat_afull;
      if (keep) exp_d.push_back(wseq);
      wseq++;
      while (!done) begin
        #(HALF - 1);
        if (in_ready) done = 1;
        else begin
          waits++;
          if (m_dbg == 0) waits_normal++;
          else if (!out_valid) stall_seen++;
          @(negedge clk);
          if (waits >= 3) begin spy_dat_afull = 1'b0; spy_len_afull = 1'b0; end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; spy_dat_afull = 1'b0; spy_len_afull = 1'b0;
    if (keep) exp_l.push_back(len);
  endtask

  task automatic close_scn(input string req);
    int bad = 0;
    repeat (3) @(negedge clk);
    if (got_d.size() != exp_d.size()) bad++;
    else foreach (exp_d[k]) if (got_d[k] != exp_d[k]) bad++;
    chk({req, " spy data"}, bad == 0, got_d.size(), exp_d.size());
    bad = 0;
    if (got_l.size() != exp_l.size()) bad++;
    else foreach (exp_l[k]) if (got_l[k] != exp_l[k]) bad++;
    chk({req, " spy length"}, bad == 0, got_l.size(), exp_l.size());
    chk({req, " drop count"}, int'(drop_count) == m_drop, int'(drop_count), m_drop);
    got_d.delete(); exp_d.delete(); got_l.delete(); exp_l.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(HALF - 1);
    // R1 reset state
    chk("R1 reset", drop_count == 0 && !spy_dat_we && !spy_len_we && in_ready, int'(drop_count), 0);
    for (int e = 0; e < 3; e++) send_event(e + 1, 1'b0, 1'b0);
    close_scn("R1");

    // R2 never modes
    cfg(0, 0, 0);
    for (int e = 0; e < 3; e++) send_event(2, 1'b0, 1'b0);
    close_scn("R2 code0");
    cfg(3, 0, 0);
    for (int e = 0; e < 3; e++) send_event(3, 1'b0, 1'b0);
    close_scn("R2 code3");

    // R3 and R6 every event, varied lengths
    cfg(1, 0, 0);
    for (int e = 0; e < 6; e++) send_event((e % 4) + 1, 1'b0, 1'b0);
    close_scn("R3 R6");

    // R4 sweep of small ratios
    for (int n = 1; n <= 6; n++) begin
      cfg(2, n - 1, 0);
      for (int e = 0; e < 2 * n + 3; e++) send_event((e % 3) + 1, 1'b0, 1'b0);
      close_scn("R4 ratio");
    end

    // R5 largest ratio
    cfg(2, 16'hFFFF, 0);
    for (int e = 0; e < 5; e++) send_event(2, 1'b0, 1'b0);
    close_scn("R5");

    // R10 restart on register write
    cfg(2, 2, 0);
    send_event(1, 1'b0, 1'b0);
    send_event(1, 1'b0, 1'b0);
    cfg(2, 2, 0);
    send_event(2, 1'b0, 1'b0);
    send_event(2, 1'b0, 1'b0);
    close_scn("R10");

    // R7 drop on almost full at start, no stall
    cfg(1, 0, 0);
    send_event(2, 1'b0, 1'b0);
    send_event(3, 1'b1, 1'b0);
    send_event(2, 1'b1, 1'b1);
    send_event(1, 1'b0, 1'b0);
    close_scn("R7");

    // R8 almost full mid-event does not truncate
    send_event(4, 1'b0, 1'b1);
    send_event(3, 1'b0, 1'b1);
    close_scn("R8");
    chk("R7 no stall in normal mode", waits_normal == 0, waits_normal, 0);

    // R9 debug hold
    cfg(1, 0, 1);
    send_event(3, 1'b1, 1'b0);
    send_event(3, 1'b0, 1'b1);
    close_scn("R9");
    chk("R9 stall observed", stall_seen >= 4, stall_seen, 4);

    // R11 saturation
    cfg(1, 0, 0);
    for (int e = 0; e < 8; e++) send_event(1, 1'b1, 1'b0);
    close_scn("R11");
    chk("R11 saturated", drop_count == 3'd7, int'(drop_count), 7);

    // R12 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    #(HALF - 1);
    chk("R12 backpressure", !in_ready && out_valid && !spy_dat_we, int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 passthrough", pass_bad == 0 && spy_noxfer == 0, pass_bad + spy_noxfer, 0);
    chk("R6 length timing", len_late == 0, len_late, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      done_flag = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule